// File: doc/BRIEF.md
# Flash Access Protection Checker

This block guards an 8 KB on-chip flash array. Every request carries one of four operations: instruction fetch, data read, word program or block erase. The block decodes the byte address, looks up the protection mode of the 2 KB region that the address falls in, and then either forwards the operation to a register-based array model or refuses it with an access-violation flag. Erase works on 1 KB blocks, so each protection region covers two erase blocks. An accepted erase fills the whole 1 KB block with ones after a fixed multi-cycle sequence. Program can only clear bits.

Requests enter on a valid/ready channel and responses leave on a second valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while an erase is running. It is also low while an earlier response is still waiting for the consumer. A response stays on its pins without change until `rsp_ready` takes it, so back-pressure on the response side stalls the request side. The protection settings are written through a plain configuration port. A region can only move away from unprotected. Reset makes every region unprotected.

Top module: `flash_guard`

## Requirements
- R1: After reset, every region is unprotected, `busy` and `rsp_valid` are low, and `req_ready` is high.
- R2: Operation codes are 00 fetch, 01 data read, 10 program and 11 erase. `req_src` is 0 for the core and 1 for the debug port. Address bits [12:11] select the 2 KB region, bits [12:10] select the 1 KB erase block, and bits [12:2] select the 32-bit word. Bits [1:0] are ignored. A served fetch or data read returns that word with `rsp_viol` low, one cycle after acceptance.
- R3: A program in an unprotected region replaces the word with the bitwise AND of the old word and `req_wdata`. The response comes one cycle after acceptance, with read data zero and `rsp_viol` low.
- R4: An erase in an unprotected region holds `busy` high for ERASE_CYCLES (default 8) cycles, starting the cycle after acceptance. On the edge where `busy` falls, every word of the addressed 1 KB block becomes all ones, and a response with `rsp_viol` low and data zero appears. The other block of the same region is left unchanged.
- R5: In a read-only region (mode 01), fetches and data reads are served. Program and erase are refused with `rsp_viol` high one cycle after acceptance, `busy` stays low, and the contents are unchanged.
- R6: In an execute-only region (mode 10, and mode 11 treated the same way), only core fetches are served. Data reads from either source, program and erase are all refused, and every refused response carries read data zero.
- R7: A fetch tagged with the debug source is handled as a data read, so in an execute-only region it is refused.
- R8: A configuration write (`cfg_we`, `cfg_region`, `cfg_mode`) takes effect from the next cycle, and only if that region is currently unprotected. Otherwise it is ignored, so a protected region never relaxes.
- R9: `req_ready` is low while `busy` is high, and also while `rsp_valid` is high with `rsp_ready` low. A response with `rsp_ready` low holds its valid, data and flag stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Operation code |
| req_src | input | 1 | Requester: 0 core, 1 debug port |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 32 | Program data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, zero for all but served reads |
| rsp_viol | output | 1 | Request was refused by protection |
| busy | output | 1 | Erase sequence in progress |
| cfg_we | input | 1 | Protection write strobe |
| cfg_region | input | 2 | Region to set |
| cfg_mode | input | 2 | New mode: 00 open, 01 read-only, 10/11 execute-only |

## Verification
Several rules are checked by assertions on every cycle. Request stalls while erasing or while a response is held, stable held responses, zero data on every refusal, the exact erase length together with its completion response, and the rule that a protected region's mode never changes. Some behaviour depends on the array's contents and on the mode chosen for each region. This includes the AND rule for program, the ones pattern after an erase and the untouched neighbour block, the per-mode split between served and refused operations, and the debug fetch being handled as a data read. Only the bench's scenarios can show these. For them, a behavioural model runs alongside the design and compares every output on every clock.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    OP_FETCH = 2'b00,
    OP_DREAD = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } fg_op_e;

  localparam logic [1:0] MODE_OPEN   = 2'b00;
  localparam logic [1:0] MODE_RDONLY = 2'b01;

  typedef struct packed {
    logic allow;
    logic rd;
    logic prog;
    logic erase;
  } fg_verdict_t;

endpackage

// File: rtl/fg_region_table.sv
module fg_region_table #(
  parameter int NREG  = 4,
  parameter int RGN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RGN_W-1:0]  cfg_region,
  input  logic [1:0]        cfg_mode,
  output logic [2*NREG-1:0] modes_o
);
  import fg_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [1:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= MODE_OPEN;
      end else if (cfg_we && cfg_region == RGN_W'(g) && mode_q == MODE_OPEN) begin
        mode_q <= cfg_mode;
      end
    end
    assign modes_o[2*g +: 2] = mode_q;
  end

endmodule

// File: rtl/fg_policy.sv
module fg_policy (
  input  logic [1:0]          op,
  input  logic                src,
  input  logic [1:0]          mode,
  output fg_pkg::fg_verdict_t verdict
);
  import fg_pkg::*;

  logic fetch_core;
  logic open_rgn;
  logic readable;

  always_comb begin
    fetch_core     = (op == OP_FETCH) && !src;
    open_rgn       = (mode == MODE_OPEN);
    readable       = open_rgn || (mode == MODE_RDONLY);
    verdict.rd     = (op == OP_FETCH) || (op == OP_DREAD);
    verdict.prog   = (op == OP_PROG);
    verdict.erase  = (op == OP_ERASE);
    if (fetch_core)      verdict.allow = 1'b1;
    else if (verdict.rd) verdict.allow = readable;
    else                 verdict.allow = open_rgn;
  end

endmodule

// File: rtl/fg_array.sv
module fg_array #(
  parameter int DATA_W    = 32,
  parameter int WORD_AW   = 11,
  parameter int BLK_W     = 3,
  parameter int BLK_WORDS = 256
) (
  input  logic               clk,
  input  logic [WORD_AW-1:0] rd_word,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               prog_en,
  input  logic [WORD_AW-1:0] prog_word,
  input  logic [DATA_W-1:0]  prog_data,
  input  logic               erase_en,
  input  logic [BLK_W-1:0]   erase_blk
);
  localparam int NWORDS = 1 << WORD_AW;
  localparam int BW_AW  = WORD_AW - BLK_W;

  logic [DATA_W-1:0] mem [NWORDS];

  assign rd_data = mem[rd_word];

  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int i = 0; i < BLK_WORDS; i++) begin
        mem[{erase_blk, BW_AW'(i)}] <= '1;
      end
    end else if (prog_en) begin
      mem[prog_word] <= mem[prog_word] & prog_data;
    end
  end

endmodule

// File: rtl/fg_sequencer.sv
module fg_sequencer #(
  parameter int ERASE_CYCLES = 8,
  parameter int BLK_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] start_blk,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] done_blk
);
  localparam int CNT_W = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
      blk_q  <= start_blk;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && (cnt_q == '0);
  assign done_blk = blk_q;

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int DATA_W       = 32,
  parameter int BLK_BYTES    = 1024,
  parameter int NBLK         = 8,
  parameter int REGION_BLKS  = 2,
  parameter int ERASE_CYCLES = 8,
  localparam int ADDR_W      = $clog2(NBLK * BLK_BYTES),
  localparam int NREG        = NBLK / REGION_BLKS,
  localparam int RGN_W       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_viol,
  output logic              busy,
  input  logic              cfg_we,
  input  logic [RGN_W-1:0]  cfg_region,
  input  logic [1:0]        cfg_mode
);
  import fg_pkg::*;

  localparam int WB_W      = $clog2(DATA_W / 8);
  localparam int WORD_AW   = ADDR_W - WB_W;
  localparam int BLK_W     = $clog2(NBLK);
  localparam int BLK_WORDS = BLK_BYTES / (DATA_W / 8);

  logic [2*NREG-1:0]  region_modes;
  logic [RGN_W-1:0]   region;
  logic [1:0]         mode;
  logic [WORD_AW-1:0] word;
  logic [BLK_W-1:0]   blk;
  fg_verdict_t        verdict;
  logic               accept;
  logic               erase_go;
  logic               prog_go;
  logic               seq_done;
  logic [BLK_W-1:0]   seq_blk;
  logic [DATA_W-1:0]  arr_rd;
  logic               unused_lo;

  assign unused_lo = ^req_addr[WB_W-1:0];
  assign region    = req_addr[ADDR_W-1 -: RGN_W];
  assign blk       = req_addr[ADDR_W-1 -: BLK_W];
  assign word      = req_addr[ADDR_W-1:WB_W];
  assign mode      = region_modes[2*region +: 2];

  assign req_ready = !busy && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign erase_go  = accept && verdict.erase && verdict.allow;
  assign prog_go   = accept && verdict.prog && verdict.allow;

  fg_region_table #(.NREG(NREG), .RGN_W(RGN_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_mode(cfg_mode), .modes_o(region_modes)
  );

  fg_policy u_policy (
    .op(req_op), .src(req_src), .mode(mode), .verdict(verdict)
  );

  fg_sequencer #(.ERASE_CYCLES(ERASE_CYCLES), .BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(erase_go), .start_blk(blk),
    .busy(busy), .done(seq_done), .done_blk(seq_blk)
  );

  fg_array #(.DATA_W(DATA_W), .WORD_AW(WORD_AW), .BLK_W(BLK_W), .BLK_WORDS(BLK_WORDS)) u_array (
    .clk(clk), .rd_word(word), .rd_data(arr_rd), .prog_en(prog_go),
    .prog_word(word), .prog_data(req_wdata), .erase_en(seq_done), .erase_blk(seq_blk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_viol  <= 1'b0;
    end else if (seq_done) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= '0;
      rsp_viol  <= 1'b0;
    end else if (accept && !erase_go) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (verdict.rd && verdict.allow) ? arr_rd : '0;
      rsp_viol  <= !verdict.allow;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int ERASE_CYCLES = 8,
  parameter int NREG         = 4,
  parameter int DATA_W       = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_viol,
  input logic              busy,
  input logic [2*NREG-1:0] region_modes
);
  int unsigned       run_cnt;
  logic [2*NREG-1:0] lock;

  for (genvar g = 0; g < NREG; g++) begin : g_lock
    assign lock[2*g +: 2] = {2{region_modes[2*g +: 2] != 2'b00}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_viol)));

  p_refused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_viol) |-> (rsp_rdata == '0));

  p_erase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == ERASE_CYCLES && rsp_valid && !rsp_viol));

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < ERASE_CYCLES));

  p_mode_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((region_modes ^ $past(region_modes)) & $past(lock)) == '0));

endmodule

bind flash_guard flash_guard_chk #(
  .ERASE_CYCLES(ERASE_CYCLES), .NREG(NREG), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_viol(rsp_viol),
  .busy(busy), .region_modes(region_modes)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  localparam int EC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic        req_src = 1'b0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_viol;
  logic        busy;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic [1:0]  cfg_mode = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_viol(rsp_viol), .busy(busy), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_mode(cfg_mode)
  );

  // behavioural reference model
  logic [31:0] mm [0:2047];
  logic [1:0]  m_modes [0:3];
  bit          m_rv;
  logic [31:0] m_rd;
  bit          m_viol;
  int          ecnt;
  int          eblk;
  string       tag = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rv = 0; m_rd = '0; m_viol = 0; ecnt = 0;
      for (int i = 0; i < 4; i++) m_modes[i] = 2'b00;
    end else begin
      bit rdy;
      int w;
      int op;
      logic [1:0] md;
      rdy = (ecnt == 0) && (!m_rv || rsp_ready);
      if (m_rv && rsp_ready) m_rv = 0;
      if (ecnt > 0) begin
        ecnt--;
        if (ecnt == 0) begin
          for (int i = 0; i < 256; i++) mm[eblk*256 + i] = 32'hFFFF_FFFF;
          m_rv = 1; m_rd = '0; m_viol = 0; tag = "R4";
        end
      end else if (req_valid && rdy) begin
        md = m_modes[req_addr[12:11]];
        w  = int'(req_addr[12:2]);
        op = int'(req_op);
        if (op == 0 && req_src) op = 1;
        m_rv = 1; m_rd = '0; m_viol = 0;
        case (op)
          0: begin m_rd = mm[w]; tag = "R2"; end
          1: begin
            if (md < 2) begin m_rd = mm[w]; tag = req_src ? "R7" : (md == 1 ? "R5" : "R2"); end
            else begin m_viol = 1; tag = req_src ? "R7" : "R6"; end
          end
          2: begin
            if (md == 0) begin mm[w] = mm[w] & req_wdata; tag = "R3"; end
            else begin m_viol = 1; tag = (md == 1) ? "R5" : "R6"; end
          end
          default: begin
            if (md == 0) begin m_rv = 0; ecnt = EC; eblk = int'(req_addr[12:10]); end
            else begin m_viol = 1; tag = (md == 1) ? "R5" : "R6"; end
          end
        endcase
      end
      if (cfg_we && m_modes[cfg_region] == 2'b00) m_modes[cfg_region] = cfg_mode;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      bit er;
      er = (ecnt == 0) && (!m_rv || rsp_ready);
      check(req_ready == er, "R9", "req_ready", 32'(req_ready), 32'(er));
      check(busy == (ecnt != 0), "R4", "busy", 32'(busy), 32'(ecnt != 0));
      check(rsp_valid == m_rv, tag, "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) begin
        check(rsp_rdata === m_rd, tag, "rsp_rdata", rsp_rdata, m_rd);
        check(rsp_viol == m_viol, tag, "rsp_viol", 32'(rsp_viol), 32'(m_viol));
      end
    end
  end

  task automatic do_req(input logic [1:0] op, input logic [12:0] addr,
                        input logic [31:0] wd, input logic src);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_src = src;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] r, input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = r; cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: idle state after reset
    check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check(busy == 1'b0, "R1", "busy", 32'(busy), 32'd0);

    // R4: erase all blocks, R2: reads of erased words
    for (int b = 0; b < 8; b++) do_req(2'b11, 13'(b * 1024), '0, 1'b0);
    idle(EC + 2);
    do_req(2'b00, 13'h000, '0, 1'b0);
    do_req(2'b01, 13'h404, '0, 1'b1);

    // R3: program clears bits, AND of successive writes
    do_req(2'b10, 13'h010, 32'hF0F0_1234, 1'b0);
    do_req(2'b10, 13'h013, 32'hFF00_FFFF, 1'b0);
    do_req(2'b00, 13'h010, '0, 1'b0);
    do_req(2'b01, 13'h011, '0, 1'b1);

    // R4: erase one block, neighbour in the same region unchanged
    do_req(2'b10, 13'h400, 32'h1234_5678, 1'b0);
    do_req(2'b10, 13'h000, 32'hA5A5_A5A5, 1'b0);
    do_req(2'b11, 13'h500, '0, 1'b0);
    do_req(2'b01, 13'h400, '0, 1'b0);
    do_req(2'b01, 13'h000, '0, 1'b0);

    // R9: response back-pressure
    @(negedge clk) rsp_ready = 1'b0;
    do_req(2'b01, 13'h010, '0, 1'b0);
    idle(4);
    @(negedge clk) rsp_ready = 1'b1;
    idle(2);

    // load regions 1..3 while open
    do_req(2'b10, 13'h0800, 32'h1111_2222, 1'b0);
    do_req(2'b10, 13'h1000, 32'h3333_4444, 1'b0);
    do_req(2'b10, 13'h1800, 32'h5555_6666, 1'b0);
    set_cfg(2'd1, 2'b01);
    set_cfg(2'd2, 2'b10);
    set_cfg(2'd3, 2'b11);

    // R5: read-only region
    do_req(2'b00, 13'h0800, '0, 1'b0);
    do_req(2'b01, 13'h0800, '0, 1'b0);
    do_req(2'b01, 13'h0800, '0, 1'b1);
    do_req(2'b10, 13'h0800, 32'h0, 1'b0);
    do_req(2'b11, 13'h0C00, '0, 1'b0);
    do_req(2'b01, 13'h0800, '0, 1'b0);

    // R6, R7: execute-only regions (modes 10 and 11)
    for (int r = 2; r < 4; r++) begin
      logic [12:0] a;
      a = 13'(r * 2048);
      do_req(2'b00, a, '0, 1'b0);
      do_req(2'b01, a, '0, 1'b0);
      do_req(2'b01, a, '0, 1'b1);
      do_req(2'b00, a, '0, 1'b1);
      do_req(2'b10, a, 32'h0, 1'b0);
      do_req(2'b11, a, '0, 1'b0);
      do_req(2'b00, a, '0, 1'b0);
    end

    // R8: relaxing writes are ignored
    set_cfg(2'd1, 2'b00);
    do_req(2'b10, 13'h0800, 32'h0, 1'b0);
    set_cfg(2'd2, 2'b01);
    do_req(2'b01, 13'h1000, '0, 1'b0);
    do_req(2'b10, 13'h0020, 32'h0F0F_0F0F, 1'b0);
    do_req(2'b00, 13'h0020, '0, 1'b0);
    set_cfg(2'd0, 2'b10);
    do_req(2'b10, 13'h0020, 32'h0, 1'b0);
    do_req(2'b00, 13'h0020, '0, 1'b0);
    do_req(2'b01, 13'h0020, '0, 1'b0);
    idle(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule